// File: doc/BRIEF.md
# External Trigger Gate Controller

This block turns an asynchronous external trigger into a timing gate. A programmable delay comes first, then a window of programmable width. It decides whether an event is accepted by checking a multiplicity-trigger result against that window. Both the delay and the width are counted in clock cycles.

A mode input selects how the block uses the window:

- **Standalone:** the external trigger alone produces an accept.
- **Coincidence:** the external trigger opens the window, and a multiplicity OK must fall inside it.
- **Validation:** a multiplicity OK opens the window, and an edge of the external input must arrive inside it.

Each sequence ends in one of two ways. A successful sequence gives a one-cycle accept pulse, together with a stop-sampling request. A failed sequence gives a one-cycle reject pulse so that readout is aborted, but only when rejects are enabled.

An inhibit input blocks new sequences from starting. Any trigger that arrives while a sequence is running is ignored. The external input is passed through a two-flop synchronizer and an edge detector before use.

Top module: `trig_gate_ctrl`

## Requirements
- R1: After reset `trig_ok`, `trig_rej` and `stop_samp` are low and no sequence is running.
- R2: The external input passes through two synchronizer flops and a rising-edge detector. An external rising edge that is first sampled at clock edge k starts a sequence at edge k+2. A level held high starts only one sequence.
- R3: In every mode the window is placed the same way. Take the edge that starts a sequence as edge 0. The window covers the cycles after edges `dly_cyc`+1 through `dly_cyc`+`win_cyc`.
- R4: `mode` = 0 or 3 is standalone. When `win_cyc` > 0, `trig_ok` is high in the cycle after the first window cycle, which is after edge `dly_cyc`+2 counted from the start edge.
- R5: `mode` = 1 is coincidence. If `mult_ok` is sampled high at an edge that ends a window cycle, `trig_ok` is high in the cycle after that edge.
- R6: `mode` = 2 is validation. A sequence starts when `mult_ok` is sampled high at an edge with no sequence running. The sequence is accepted if a detected external rising edge is sampled at an edge that ends a window cycle.
- R7: If the window closes without success, `trig_rej` pulses after the edge that ends the last window cycle when `rej_en` = 1. When `rej_en` = 0 there is no pulse.
- R8: With `win_cyc` = 0 the window never opens. The failure outcome of R7 is then taken at edge `dly_cyc`+1 counted from the start edge.
- R9: While `inhibit` is high, no sequence starts, and no outcome follows the blocked trigger.
- R10: A start event that arrives while a sequence is running is ignored. It neither restarts nor adds an outcome.
- R11: `trig_ok` and `trig_rej` are never high together, and each lasts one cycle. `stop_samp` is high exactly in the cycles where `trig_ok` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_trig_a | input | 1 | Asynchronous external trigger / validation |
| mult_ok | input | 1 | Synchronous multiplicity-trigger result |
| inhibit | input | 1 | Blocks new sequences |
| mode | input | 2 | 0/3 standalone, 1 coincidence, 2 validation |
| rej_en | input | 1 | Enables the reject pulse on failure |
| dly_cyc | input | 16 | Delay before the window, in cycles |
| win_cyc | input | 16 | Window width, in cycles |
| trig_ok | output | 1 | Accept pulse |
| trig_rej | output | 1 | Reject pulse |
| stop_samp | output | 1 | Stop-sampling request |

## Verification
The main function is exercised with random delays, widths and modes. The hit is placed at random just before the window, on each of its edge cycles, or just after it, or left out entirely. These cases separate an off-by-one in the delay counter from one in the width counter.

Directed cases cover the remaining behaviours:
- A zero delay separates the start path from the counting path.
- A zero width isolates the never-open rule.
- A held trigger shows whether the edge detector works.
- A second trigger during the delay shows whether busy sequences ignore new starts.
- Inhibited triggers are confirmed to leave no trace on any output.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int unsigned CNT_W_DEF = 16;

  typedef enum logic [1:0] {
    MODE_SOLO  = 2'd0,
    MODE_COIN  = 2'd1,
    MODE_VALID = 2'd2,
    MODE_SOLO2 = 2'd3
  } tg_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_GATE  = 2'd2
  } tg_state_e;

  // window counter preload: counts down to zero on the last open cycle
  function automatic logic [CNT_W_DEF-1:0] win_preload(input logic [CNT_W_DEF-1:0] w);
    return w - 1'b1;
  endfunction

  function automatic logic cnt_done(input logic [CNT_W_DEF-1:0] c);
    return (c == '0);
  endfunction

  function automatic logic solo_mode(input tg_mode_e m);
    return (m == MODE_SOLO) || (m == MODE_SOLO2);
  endfunction
endpackage

// File: rtl/tg_sync_edge.sv
module tg_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_a,
  output logic rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= din_a;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din_a};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[LAST];

  assign rise = chain[LAST] & ~prev;
endmodule

// File: rtl/tg_gate_fsm.sv
module tg_gate_fsm
  import tg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit,
  input  logic             solo,
  input  logic             rej_en,
  input  logic [CNT_W-1:0] dly,
  input  logic [CNT_W-1:0] win,
  output logic             ok,
  output logic             rej,
  output logic             busy,
  output logic             gate_open
);
  tg_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic             win_zero;

  assign win_zero  = (win == '0);
  assign busy      = (st != ST_IDLE);
  assign gate_open = (st == ST_GATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      ok  <= 1'b0;
      rej <= 1'b0;
    end else begin
      ok  <= 1'b0;
      rej <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st  <= ST_DELAY;
            cnt <= dly;
          end
        end
        ST_DELAY: begin
          if (cnt_done(cnt)) begin
            if (win_zero) begin
              st  <= ST_IDLE;
              rej <= rej_en;
            end else begin
              st  <= ST_GATE;
              cnt <= win_preload(win);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GATE: begin
          if (hit || solo) begin
            st <= ST_IDLE;
            ok <= 1'b1;
          end else if (cnt_done(cnt)) begin
            st  <= ST_IDLE;
            rej <= rej_en;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trig_gate_ctrl.sv
module trig_gate_ctrl
  import tg_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_trig_a,
  input  logic             mult_ok,
  input  logic             inhibit,
  input  logic [1:0]       mode,
  input  logic             rej_en,
  input  logic [CNT_W-1:0] dly_cyc,
  input  logic [CNT_W-1:0] win_cyc,
  output logic             trig_ok,
  output logic             trig_rej,
  output logic             stop_samp
);
  tg_mode_e mode_e;
  logic     ext_rise_w;
  logic     start_raw_w;
  logic     start_w;
  logic     hit_w;
  logic     solo_w;
  logic     busy_w;
  logic     gate_open_w;
  logic     ok_w;
  logic     rej_w;

  assign mode_e = tg_mode_e'(mode);

  tg_sync_edge #(.STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din_a (ext_trig_a),
    .rise  (ext_rise_w)
  );

  assign solo_w      = solo_mode(mode_e);
  assign start_raw_w = (mode_e == MODE_VALID) ? mult_ok : ext_rise_w;
  assign start_w     = start_raw_w & ~inhibit;
  assign hit_w       = (mode_e == MODE_COIN)  ? mult_ok :
                       (mode_e == MODE_VALID) ? ext_rise_w : 1'b0;

  tg_gate_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .hit       (hit_w),
    .solo      (solo_w),
    .rej_en    (rej_en),
    .dly       (dly_cyc),
    .win       (win_cyc),
    .ok        (ok_w),
    .rej       (rej_w),
    .busy      (busy_w),
    .gate_open (gate_open_w)
  );

  assign trig_ok   = ok_w;
  assign trig_rej  = rej_w;
  assign stop_samp = ok_w;
endmodule

// File: rtl/tg_gate_chk.sv
module tg_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic trig_ok,
  input logic trig_rej,
  input logic inhibit,
  input logic busy,
  input logic gate_open
);
  // R11
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_ok && trig_rej));
  // R11
  ok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |=> !trig_ok);
  // R11
  rej_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rej |=> !trig_rej);
  // R3
  ok_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ok |-> $past(gate_open));
  // R7
  rej_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rej |-> $past(busy));
  // R9
  inhibit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && inhibit) |=> !busy);
endmodule

bind trig_gate_ctrl tg_gate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_ok   (trig_ok),
  .trig_rej  (trig_rej),
  .inhibit   (inhibit),
  .busy      (busy_w),
  .gate_open (gate_open_w)
);

// File: tb/tb_trig_gate_ctrl.sv
`timescale 1ns/1ps
module tb_trig_gate_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_trig_a = 1'b0;
  logic        mult_ok = 1'b0;
  logic        inhibit = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        rej_en = 1'b1;
  logic [15:0] dly_cyc = '0;
  logic [15:0] win_cyc = '0;
  logic        trig_ok, trig_rej, stop_samp;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // results of the last case
  int got_kind, got_e, npulse, stop_mis;

  always #2.5 clk = ~clk;

  trig_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_trig_a(ext_trig_a), .mult_ok(mult_ok),
    .inhibit(inhibit), .mode(mode), .rej_en(rej_en), .dly_cyc(dly_cyc),
    .win_cyc(win_cyc), .trig_ok(trig_ok), .trig_rej(trig_rej), .stop_samp(stop_samp)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected outcome: kind 0 none / 1 accept / 2 reject, at edge index
  function automatic void expect_case(input int m, input int rj, input int d,
                                      input int w, input int hit, input int inh,
                                      output int kind, output int edge_i);
    int fk;
    fk = rj ? 2 : 0;
    kind = 0; edge_i = 0;
    if (inh != 0) return;
    if (m == 0 || m == 3) begin
      if (w == 0) begin kind = fk; edge_i = 4 + d; end
      else        begin kind = 1;  edge_i = 5 + d; end
    end else if (m == 1) begin
      if (w > 0 && hit >= 5 + d && hit <= 4 + d + w) begin kind = 1; edge_i = hit; end
      else begin kind = fk; edge_i = 4 + d + w; end
    end else begin
      if (w > 0 && hit > 0 && hit + 2 >= 3 + d && hit + 2 <= 2 + d + w) begin
        kind = 1; edge_i = hit + 2;
      end else begin kind = fk; edge_i = 2 + d + w; end
    end
  endfunction

  // hit: mode1 = edge where mult_ok is high, mode2 = first edge of ext pulse
  task automatic run_case(input int m, input int rj, input int d, input int w,
                          input int hit, input int inh, input int hold, input int again);
    int lim;
    mode = m[1:0]; rej_en = rj[0]; dly_cyc = d[15:0]; win_cyc = w[15:0];
    got_kind = 0; got_e = 0; npulse = 0; stop_mis = 0;
    lim = 14 + d + w + hold;
    for (int e = 1; e <= lim; e++) begin
      @(negedge clk);
      inhibit = (inh != 0);
      if (m == 2) begin
        mult_ok    = (e == 1);
        ext_trig_a = (hit > 0) && (e == hit || e == hit + 1);
      end else begin
        mult_ok    = (m == 1) ? (e == hit) : $urandom_range(0, 1) == 1;
        ext_trig_a = (e <= hold) || (again > 0 && (e == again || e == again + 1));
      end
      @(posedge clk); #1;
      if (stop_samp != trig_ok) stop_mis++;
      if (trig_ok || trig_rej) begin
        npulse++;
        if (got_kind == 0) begin got_kind = trig_ok ? 1 : 2; got_e = e; end
      end
    end
    @(negedge clk);
    ext_trig_a = 0; mult_ok = 0; inhibit = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic judge(input string req, input int m, input int rj, input int d,
                       input int w, input int hit, input int inh);
    int ek, ee;
    expect_case(m, rj, d, w, hit, inh, ek, ee);
    chk(got_kind == ek, req, got_kind, ek);
    if (ek != 0) chk(got_e == ee, req, got_e, ee);
    chk(npulse == (ek != 0 ? 1 : 0), "R11 pulse count", npulse, ek != 0 ? 1 : 0);
    chk(stop_mis == 0, "R11 stop_samp", stop_mis, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int m, rj, d, w, hit;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({trig_ok, trig_rej, stop_samp} == 3'b000, "R1 during reset", {trig_ok, trig_rej, stop_samp}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({trig_ok, trig_rej, stop_samp} == 3'b000, "R1 after reset", {trig_ok, trig_rej, stop_samp}, 0);

    // R4 standalone, mode 0 and 3, zero delay included
    run_case(0, 1, 3, 4, 0, 0, 2, 0); judge("R4 solo", 0, 1, 3, 4, 0, 0);
    run_case(3, 1, 0, 1, 0, 0, 2, 0); judge("R4 solo mode3 d0", 3, 1, 0, 1, 0, 0);
    // R2 held level starts only one sequence
    run_case(0, 1, 1, 2, 0, 0, 20, 0); judge("R2 held trigger", 0, 1, 1, 2, 0, 0);
    // R8 zero width
    run_case(0, 1, 2, 0, 0, 0, 2, 0); judge("R8 width0 solo", 0, 1, 2, 0, 0, 0);
    run_case(1, 1, 0, 0, 5, 0, 2, 0); judge("R8 width0 coin", 1, 1, 0, 0, 5, 0);
    // R5 window edges
    run_case(1, 1, 2, 3, 7, 0, 2, 0); judge("R5 first window cycle", 1, 1, 2, 3, 7, 0);
    run_case(1, 1, 2, 3, 9, 0, 2, 0); judge("R5 last window cycle", 1, 1, 2, 3, 9, 0);
    run_case(1, 1, 2, 3, 6, 0, 2, 0); judge("R3 hit before window", 1, 1, 2, 3, 6, 0);
    run_case(1, 1, 2, 3, 10, 0, 2, 0); judge("R7 hit after window", 1, 1, 2, 3, 10, 0);
    // R7 reject disabled
    run_case(1, 0, 2, 3, 0, 0, 2, 0); judge("R7 reject off", 1, 0, 2, 3, 0, 0);
    // R6 validation
    run_case(2, 1, 1, 3, 2, 0, 0, 0); judge("R6 validation ok", 2, 1, 1, 3, 2, 0);
    run_case(2, 1, 1, 3, 0, 0, 0, 0); judge("R6 no validation", 2, 1, 1, 3, 0, 0);
    // R9 inhibit
    run_case(0, 1, 1, 2, 0, 1, 2, 0); judge("R9 inhibit solo", 0, 1, 1, 2, 0, 1);
    run_case(2, 1, 1, 2, 2, 1, 0, 0); judge("R9 inhibit valid", 2, 1, 1, 2, 2, 1);
    // R10 second trigger during delay ignored
    run_case(0, 1, 6, 2, 0, 0, 2, 5); judge("R10 busy ignore", 0, 1, 6, 2, 0, 0);

    // random mix
    for (int i = 0; i < 80; i++) begin
      m  = $urandom_range(0, 3);
      rj = $urandom_range(0, 1);
      d  = $urandom_range(0, 6);
      w  = $urandom_range(0, 6);
      if (m == 2) hit = $urandom_range(0, 5 + d + w);
      else        hit = $urandom_range(0, 7 + d + w);
      run_case(m, rj, d, w, hit, 0, 2, 0);
      judge(m == 1 ? "R5 random" : (m == 2 ? "R6 random" : "R4 random"), m, rj, d, w, hit, 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule